// File: doc/BRIEF.md
# Byte-Wide Serial Port Register Bank

This block is the host-facing register file of a classic byte-wide serial port. A processor reaches eight registers through a 3-bit offset with separate write and read strobes. The block keeps the line, modem and interrupt control state and merges the receive-data and transmitter-empty sources into one interrupt line by fixed priority. The rest of the port sits behind two byte streams. Writing the data register offers a byte on a transmit valid/ready stream. A receive stream delivers bytes and break events, one at a time, into a single holding register.

A line-control bit, the divisor-access bit (bit 7 of offset 3), turns offsets 0 and 1 into the low and high bytes of a 16-bit rate divisor. When the loopback bit is set, the modem-status view is rebuilt from the modem-control bits. Bit timing, the baud generator and FIFOs are outside the block.

Transmit uses a two-state machine. `TXS_IDLE` means the holding register is free. Loading the data register (transition *load*) enters `TXS_BUSY`. Acceptance downstream (transition *handoff*) returns to `TXS_IDLE`. A load while busy (transition *reload*) stays in `TXS_BUSY` with the new byte.

Top module: `sio_regbank`

## Requirements
- R1: After reset, line status (offset 5) reads 0x60, interrupt identity (offset 2) reads 0x01, modem status (offset 6) reads 0xB0 with modem_in = 4'b1011, irq is low, tx_valid is low and rx_ready is high.
- R2: Scratch (offset 7) and line control (offset 3) read back exactly the byte last written.
- R3: While line-control bit 7 is set, offsets 0 and 1 write and read the divisor low and high bytes. A write to offset 0 then sends nothing, and interrupt enable is left unchanged.
- R4: Interrupt enable keeps only bits 3:0 of a write and modem control keeps only bits 4:0. Writes to offsets 2, 5 and 6 change nothing.
- R5: The identity is 0x04 when data-ready (line-status bit 0) and enable bit 0 are both set. Otherwise it is 0x02 when the transmitter-empty pending flag and enable bit 1 are set. Otherwise it is 0x01. irq is high exactly when the identity is not 0x01.
- R6: A data write with bit 7 clear puts the byte on tx_data with tx_valid high from the next cycle. The byte holds until tx_ready. Meanwhile line-status bits 6 and 5 are clear and the pending flag is clear. On acceptance, bits 6 and 5 return to 1 and the pending flag is set.
- R7: Reading offset 2 while it reports 0x02 clears the pending flag. A write to interrupt enable while the transmitter is idle sets the flag. The same write while busy does not.
- R8: Reading offset 0 with bit 7 clear returns the held byte and clears data-ready (bit 0) and break (bit 4) of line status.
- R9: rx_ready equals NOT data-ready. A byte offered while data-ready is set is dropped. An accepted byte is stored and sets data-ready. An accepted break (rx_break high) stores 0x00 and sets line-status bits 4 and 0.
- R10: With modem-control bit 4 set, modem status reads {OUT2 (mctl bit 3), OUT1 (bit 2), DTR (bit 0), RTS (bit 1), 4'b0000}. Otherwise it reads {modem_in, 4'b0000}, with modem_in ordered {carrier, ring, set-ready, clear-to-send}.
- R11: bus_rdata is registered. It changes only in the cycle after a read strobe, and read side effects happen only in the strobe cycle.
- R12: When a byte arrives in the same cycle as a data-register read, the read returns the old byte and the new byte is kept with data-ready set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Transmit byte accepted |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive item offered |
| rx_break | input | 1 | Offered item is a break event |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Holding register free |
| modem_in | input | 4 | Carrier, ring, set-ready, clear-to-send |
| modem_out | output | 4 | OUT2, OUT1, RTS, DTR from modem control bits 3:0 |

## Verification
Two events can land in the same cycle: a receive byte being accepted and a read of the data register. The bench raises both strobes on one edge while the holding register is free. It then checks three things: the read returns the old byte, line status shows data-ready, and a second read returns the new byte. The interrupt-identity priority is provoked by making receive data and transmitter-empty pending at once. The bench checks that 0x04 wins, that reading it leaves the pending flag alone, and that 0x02 appears once the byte is read out.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int SIO_AW     = 3;
    localparam int SIO_DW     = 8;
    localparam int SIO_DIVW   = 2 * SIO_DW;
    localparam int SIO_IEN_W  = 4;
    localparam int SIO_MCTL_W = 5;
    localparam int SIO_MDM_W  = 4;

    typedef enum logic [SIO_AW-1:0] {
        OFS_DATA  = 3'd0,
        OFS_IEN   = 3'd1,
        OFS_IID   = 3'd2,
        OFS_LCTL  = 3'd3,
        OFS_MCTL  = 3'd4,
        OFS_LSTAT = 3'd5,
        OFS_MSTAT = 3'd6,
        OFS_SCR   = 3'd7
    } sio_ofs_e;

    typedef enum logic {
        TXS_IDLE = 1'b0,
        TXS_BUSY = 1'b1
    } sio_txs_e;

    localparam logic [SIO_DW-1:0] IID_NONE  = 8'h01;
    localparam logic [SIO_DW-1:0] IID_THRE  = 8'h02;
    localparam logic [SIO_DW-1:0] IID_RXD   = 8'h04;
    localparam logic [SIO_DW-1:0] MSTAT_RST = 8'hB0;
endpackage

// File: rtl/sio_tx_ctrl.sv
module sio_tx_ctrl
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SIO_DW-1:0] load_data,
    input  logic              ien_wr,
    input  logic              iid_ack,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [SIO_DW-1:0] tx_data,
    output logic              idle,
    output logic              thre_pend
);
    sio_txs_e          state_q, state_d;
    logic [SIO_DW-1:0] hold_q;
    logic              handoff;

    // next-state: load, reload, handoff
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXS_IDLE: if (load) state_d = TXS_BUSY;
            TXS_BUSY: begin
                if (load)          state_d = TXS_BUSY;
                else if (tx_ready) state_d = TXS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TXS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        tx_valid = (state_q == TXS_BUSY);
        idle     = (state_q == TXS_IDLE);
        tx_data  = hold_q;
        handoff  = tx_valid && tx_ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q    <= '0;
            thre_pend <= 1'b0;
        end else begin
            if (load) hold_q <= load_data;
            if (load)                  thre_pend <= 1'b0;
            else if (handoff)          thre_pend <= 1'b1;
            else if (iid_ack)          thre_pend <= 1'b0;
            else if (ien_wr && idle)   thre_pend <= 1'b1;
        end
    end
endmodule

// File: rtl/sio_rx_hold.sv
module sio_rx_hold
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_break,
    input  logic [SIO_DW-1:0] rx_data,
    input  logic              rbr_rd,
    output logic              rx_ready,
    output logic [SIO_DW-1:0] rbr,
    output logic              data_rdy,
    output logic              brk_seen
);
    logic accept;

    assign rx_ready = !data_rdy;
    assign accept   = rx_valid && rx_ready;

    // arrival outranks a same-cycle read of the holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbr      <= '0;
            data_rdy <= 1'b0;
            brk_seen <= 1'b0;
        end else if (accept) begin
            rbr      <= rx_break ? '0 : rx_data;
            data_rdy <= 1'b1;
            brk_seen <= rx_break;
        end else if (rbr_rd) begin
            data_rdy <= 1'b0;
            brk_seen <= 1'b0;
        end
    end
endmodule

// File: rtl/sio_irq_prio.sv
module sio_irq_prio
    import sio_pkg::*;
(
    input  logic                 data_rdy,
    input  logic                 thre_pend,
    input  logic [SIO_IEN_W-1:0] ien,
    output logic [SIO_DW-1:0]    iid,
    output logic                 irq
);
    always_comb begin
        if (data_rdy && ien[0])       iid = IID_RXD;
        else if (thre_pend && ien[1]) iid = IID_THRE;
        else                          iid = IID_NONE;
        irq = (iid != IID_NONE);
    end
endmodule

// File: rtl/sio_regbank.sv
module sio_regbank
    import sio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SIO_AW-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [SIO_DW-1:0]    bus_wdata,
    output logic [SIO_DW-1:0]    bus_rdata,
    output logic                 irq,
    output logic                 tx_valid,
    input  logic                 tx_ready,
    output logic [SIO_DW-1:0]    tx_data,
    input  logic                 rx_valid,
    input  logic                 rx_break,
    input  logic [SIO_DW-1:0]    rx_data,
    output logic                 rx_ready,
    input  logic [SIO_MDM_W-1:0] modem_in,
    output logic [SIO_MDM_W-1:0] modem_out
);
    sio_ofs_e                ofs;
    logic [SIO_IEN_W-1:0]    ien_q;
    logic [SIO_DW-1:0]       lctl_q;
    logic [SIO_MCTL_W-1:0]   mctl_q;
    logic [SIO_DW-1:0]       scr_q;
    logic [SIO_DIVW-1:0]     div_q;
    logic [SIO_DW-1:0]       mstat_q;
    logic [SIO_DW-1:0]       rd_mux, lstat, mview, iid, rbr;
    logic                    dlab, tx_idle, thre_pend, data_rdy, brk_seen;
    logic                    wr_thr, wr_ien, rd_rbr, iid_ack;

    assign ofs    = sio_ofs_e'(bus_addr);
    assign dlab   = lctl_q[SIO_DW-1];
    assign wr_thr = bus_wr && ofs == OFS_DATA && !dlab;
    assign wr_ien = bus_wr && ofs == OFS_IEN  && !dlab;
    assign rd_rbr = bus_rd && ofs == OFS_DATA && !dlab;
    assign iid_ack = bus_rd && ofs == OFS_IID && iid == IID_THRE;

    sio_tx_ctrl u_tx (
        .clk(clk), .rst_n(rst_n), .load(wr_thr), .load_data(bus_wdata),
        .ien_wr(wr_ien), .iid_ack(iid_ack), .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .idle(tx_idle),
        .thre_pend(thre_pend)
    );

    sio_rx_hold u_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_break(rx_break),
        .rx_data(rx_data), .rbr_rd(rd_rbr), .rx_ready(rx_ready), .rbr(rbr),
        .data_rdy(data_rdy), .brk_seen(brk_seen)
    );

    sio_irq_prio u_prio (
        .data_rdy(data_rdy), .thre_pend(thre_pend), .ien(ien_q),
        .iid(iid), .irq(irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q  <= '0;
            lctl_q <= '0;
            mctl_q <= '0;
            scr_q  <= '0;
            div_q  <= '0;
        end else if (bus_wr) begin
            unique case (ofs)
                OFS_DATA: if (dlab) div_q[SIO_DW-1:0] <= bus_wdata;
                OFS_IEN: begin
                    if (dlab) div_q[SIO_DIVW-1:SIO_DW] <= bus_wdata;
                    else      ien_q <= bus_wdata[SIO_IEN_W-1:0];
                end
                OFS_LCTL: lctl_q <= bus_wdata;
                OFS_MCTL: mctl_q <= bus_wdata[SIO_MCTL_W-1:0];
                OFS_SCR:  scr_q  <= bus_wdata;
                OFS_IID, OFS_LSTAT, OFS_MSTAT: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mstat_q <= MSTAT_RST;
        else        mstat_q <= {modem_in, {(SIO_DW-SIO_MDM_W){1'b0}}};
    end

    always_comb begin
        lstat = {1'b0, tx_idle, tx_idle, brk_seen, 3'b000, data_rdy};
        if (mctl_q[4])
            mview = {mctl_q[3], mctl_q[2], mctl_q[0], mctl_q[1], 4'b0000};
        else
            mview = mstat_q;
        unique case (ofs)
            OFS_DATA:  rd_mux = dlab ? div_q[SIO_DW-1:0] : rbr;
            OFS_IEN:   rd_mux = dlab ? div_q[SIO_DIVW-1:SIO_DW]
                                     : {{(SIO_DW-SIO_IEN_W){1'b0}}, ien_q};
            OFS_IID:   rd_mux = iid;
            OFS_LCTL:  rd_mux = lctl_q;
            OFS_MCTL:  rd_mux = {{(SIO_DW-SIO_MCTL_W){1'b0}}, mctl_q};
            OFS_LSTAT: rd_mux = lstat;
            OFS_MSTAT: rd_mux = mview;
            OFS_SCR:   rd_mux = scr_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign modem_out = mctl_q[SIO_MDM_W-1:0];
endmodule

// File: rtl/sio_regbank_chk.sv
module sio_regbank_chk
    import sio_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [SIO_AW-1:0]    bus_addr,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [SIO_DW-1:0]    bus_wdata,
    input logic [SIO_DW-1:0]    bus_rdata,
    input logic                 irq,
    input logic                 tx_valid,
    input logic                 tx_ready,
    input logic [SIO_DW-1:0]    tx_data,
    input logic                 rx_valid,
    input logic                 rx_ready,
    input logic                 dlab,
    input logic [SIO_IEN_W-1:0] ien
);
    logic thr_load;
    assign thr_load = bus_wr && bus_addr == 3'd0 && !dlab;

    a_r6_load_emits: assert property (@(posedge clk) disable iff (!rst_n)
        thr_load |=> (tx_valid && tx_data == $past(bus_wdata)));

    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !thr_load) |=> (tx_valid && $stable(tx_data)));

    a_r9_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready) |=> !rx_ready);

    a_r5_rx_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ready && ien[0]) |-> irq);

    a_r5_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ien[1:0] == 2'b00) |-> !irq);

    a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind sio_regbank sio_regbank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .dlab(lctl_q[7]), .ien(ien_q)
);

// File: tb/sio_regbank_bench.sv
`timescale 1ns/1ps
module sio_regbank_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata, tx_data;
    logic       irq, tx_valid, rx_ready;
    logic       tx_ready = 1'b0, rx_valid = 1'b0, rx_break = 1'b0;
    logic [7:0] rx_data = '0;
    logic [3:0] modem_in = 4'b1011, modem_out;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic rd_d = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    sio_regbank u_sio_regbank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_break(rx_break), .rx_data(rx_data),
        .rx_ready(rx_ready), .modem_in(modem_in), .modem_out(modem_out)
    );

    task automatic judge(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    // monitor: one registered result per read strobe seen at an edge
    always @(posedge clk) rd_d <= bus_rd;
    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) judge("R11 unexpected read", bus_rdata, 8'h00);
            else judge(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic rx_send(input logic [7:0] d, input logic brk);
        @(negedge clk); rx_valid = 1'b1; rx_data = d; rx_break = brk;
        @(negedge clk); rx_valid = 1'b0; rx_break = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R11 watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        judge("R1 irq", {7'd0, irq}, 8'h00);
        judge("R1 tx_valid", {7'd0, tx_valid}, 8'h00);
        judge("R1 rx_ready", {7'd0, rx_ready}, 8'h01);
        rd(3'd5, 8'h60, "R1 lstat");
        rd(3'd2, 8'h01, "R1 iid");
        rd(3'd6, 8'hB0, "R1 mstat");
        // R2 scratch and line control
        wr(3'd7, 8'h5A); rd(3'd7, 8'h5A, "R2 scratch");
        wr(3'd3, 8'h1B); rd(3'd3, 8'h1B, "R2 lctl");
        // R3 divisor remap
        wr(3'd3, 8'h80); wr(3'd0, 8'h34); wr(3'd1, 8'h12);
        judge("R3 no send", {7'd0, tx_valid}, 8'h00);
        rd(3'd0, 8'h34, "R3 div lo"); rd(3'd1, 8'h12, "R3 div hi");
        wr(3'd3, 8'h03); rd(3'd1, 8'h00, "R3 ien untouched");
        // R4 masking and ignored offsets
        wr(3'd1, 8'hFF); rd(3'd1, 8'h0F, "R4 ien mask");
        wr(3'd1, 8'h00);
        wr(3'd4, 8'hFF); rd(3'd4, 8'h1F, "R4 mctl mask");
        wr(3'd2, 8'hAA); wr(3'd5, 8'h00); wr(3'd6, 8'h00);
        rd(3'd5, 8'h60, "R4 lstat ignored"); rd(3'd2, 8'h01, "R4 iid ignored");
        // R10 loopback view
        rd(3'd6, 8'hF0, "R10 loop all");
        wr(3'd4, 8'h15); rd(3'd6, 8'h60, "R10 loop out1 dtr");
        wr(3'd4, 8'h1A); rd(3'd6, 8'h90, "R10 loop out2 rts");
        judge("R10 modem_out", {4'd0, modem_out}, 8'h0A);
        wr(3'd4, 8'h00); modem_in = 4'b0100;
        @(negedge clk); rd(3'd6, 8'h40, "R10 pins");
        modem_in = 4'b1011;
        // R7 pending flag
        wr(3'd1, 8'h02);
        judge("R5 irq thre", {7'd0, irq}, 8'h01);
        rd(3'd2, 8'h02, "R7 iid thre");
        judge("R7 ack clears irq", {7'd0, irq}, 8'h00);
        rd(3'd2, 8'h01, "R7 iid after ack");
        wr(3'd1, 8'h02);
        judge("R7 ien rearms", {7'd0, irq}, 8'h01);
        // R6 transmit
        wr(3'd0, 8'hC3);
        judge("R6 valid", {7'd0, tx_valid}, 8'h01);
        judge("R6 data", tx_data, 8'hC3);
        judge("R6 pend cleared", {7'd0, irq}, 8'h00);
        rd(3'd5, 8'h00, "R6 busy lstat");
        wr(3'd1, 8'h02);
        judge("R7 busy no rearm", {7'd0, irq}, 8'h00);
        repeat (3) @(negedge clk);
        judge("R6 held", tx_data, 8'hC3);
        tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
        judge("R6 handoff valid", {7'd0, tx_valid}, 8'h00);
        judge("R6 handoff irq", {7'd0, irq}, 8'h01);
        rd(3'd5, 8'h60, "R6 idle lstat");
        rd(3'd2, 8'h02, "R6 iid");
        // R5 priority with both sources
        wr(3'd1, 8'h03);
        rx_send(8'hA5, 1'b0);
        judge("R9 full", {7'd0, rx_ready}, 8'h00);
        rd(3'd2, 8'h04, "R5 rx wins");
        rx_send(8'h77, 1'b0);
        rd(3'd0, 8'hA5, "R8 data");
        rd(3'd2, 8'h02, "R5 thre next");
        rd(3'd5, 8'h60, "R8 dr cleared");
        judge("R5 irq idle", {7'd0, irq}, 8'h00);
        rd(3'd0, 8'hA5, "R9 drop while full");
        // R9 break
        rx_send(8'h99, 1'b1);
        rd(3'd5, 8'h71, "R9 break lstat");
        rd(3'd0, 8'h00, "R9 break data");
        rd(3'd5, 8'h60, "R8 break cleared");
        // R12 arrival during data read
        exp_q.push_back(8'h00); tag_q.push_back("R12 old byte");
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 3'd0; rx_valid = 1'b1; rx_data = 8'h3C;
        @(negedge clk);
        bus_rd = 1'b0; rx_valid = 1'b0;
        rd(3'd5, 8'h61, "R12 dr kept");
        rd(3'd0, 8'h3C, "R12 new byte");
        // R11 registered read holds
        wr(3'd7, 8'h11); @(negedge clk);
        judge("R11 rdata holds", bus_rdata, 8'h3C);
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) judge("R11 reads outstanding", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule